// File: doc/BRIEF.md
# Configuration Image Update Sequencer

This block moves a configuration image from a shared staging SRAM into a nonvolatile configuration memory. It then copies the stored contents back into the same SRAM region so the host can compare them with what it wrote. After the host has checked the copy, a separate command tells the memory to reload the target device. The host fills the staging SRAM through its own port. It then writes a store command that carries a base address, a length, a target select and a segment offset. For the whole store, the controller holds exclusive use of the SRAM.

The memory side is an abstract byte stream. Each byte is flagged as either an opcode or an address/data byte, and the memory throttles the stream with a busy signal. A large image can be sent in segments. Each segment is stored, read back and verified before the next one is sent. The segment offset places each piece in its own region of the memory. Only the segment at offset zero erases the target.

States and transitions:
- IDLE goes to ERASE on a store with offset zero. It goes to PROG_OP on a store with a nonzero offset, and to RELOAD on an accepted reload.
- ERASE goes to PROG_OP. PROG_OP goes to PROG_ADR.
- PROG_ADR goes to PROG_FETCH after the last address byte.
- PROG_FETCH goes to PROG_DATA.
- PROG_DATA goes back to PROG_FETCH. After the last byte it goes to READ_OP.
- READ_OP goes to READ_ADR. READ_ADR goes to READ_REQ.
- READ_REQ goes to READ_WAIT. READ_WAIT goes back to READ_REQ, or to IDLE after the last byte.
- RELOAD goes to IDLE.

Every byte state leaves only on a cycle in which its byte is accepted.

Top module: `cfg_image_updater`

## Requirements
- R1: After reset, busy, done and err are 0, phase is 0, and the host port reaches the SRAM: host writes land, and host reads return the addressed word.
- R2: A store command (cmd_code 1, nonzero cfg_len) is accepted in idle. The controller then owns the SRAM until the readback ends, and host writes made during that time have no effect on the SRAM.
- R3: A store with seg_off equal to 0 begins with the erase opcode 0xE5, and a store with nonzero seg_off sends no erase. Every byte is held, unchanged and with mem_req high, until a cycle in which mem_busy is low, so the long erase stalls the next byte.
- R4: Programming sends opcode 0x5A, then MEM_AW/8 address bytes equal to seg_off with the most significant byte first, then cfg_len data bytes taken from SRAM addresses cfg_base to cfg_base+cfg_len-1. mem_op is 1 only on opcode bytes.
- R5: Readback sends opcode 0xA5 and the same address bytes, then one request byte (mem_op 0, value 0) for each byte. Each mem_rd_valid byte is written to SRAM address cfg_base+i.
- R6: After the last readback byte is written, busy falls, done rises and the host owns the SRAM again. done clears when the next command is accepted.
- R7: A reload command (cmd_code 2) is accepted only while done is 1. It then sends opcode 0xC3 exactly once.
- R8: The following commands are ignored and set err: a command while busy, a reload while done is 0, a store with cfg_len 0, and cmd_code 0 or 3. err stays set until reset.
- R9: phase shows the state: 0 IDLE, 1 ERASE, 2 PROG_OP, 3 PROG_ADR, 4 PROG_FETCH, 5 PROG_DATA, 6 READ_OP, 7 READ_ADR, 8 READ_REQ, 9 READ_WAIT, 10 RELOAD.
- R10: tgt_sel is captured when a command is accepted and drives mem_tgt for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 1 store, 2 reload |
| cfg_base | input | SRAM_AW | SRAM start of the image |
| cfg_len | input | LEN_W | Image length in bytes |
| seg_off | input | MEM_AW | Memory start address of the segment |
| tgt_sel | input | TGT_W | Target device select |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Store and readback finished |
| err | output | 1 | Sticky rejected-command flag |
| phase | output | 4 | Current state code |
| h_addr | input | SRAM_AW | Host SRAM address |
| h_wdata | input | 8 | Host SRAM write data |
| h_we | input | 1 | Host SRAM write enable |
| h_rdata | output | 8 | Host SRAM read data |
| sram_addr | output | SRAM_AW | SRAM address |
| sram_wdata | output | 8 | SRAM write data |
| sram_we | output | 1 | SRAM write enable |
| sram_rdata | input | 8 | SRAM read data, one-cycle latency |
| mem_req | output | 1 | Byte offered to memory |
| mem_op | output | 1 | Byte is an opcode |
| mem_byte | output | 8 | Byte value |
| mem_tgt | output | TGT_W | Target being addressed |
| mem_busy | input | 1 | Memory cannot take a byte |
| mem_rd_valid | input | 1 | Readback byte strobe |
| mem_rd_byte | input | 8 | Readback byte |

## Verification
The hardest case to reach is proof that the readback really comes from the memory. A copy taken from the memory looks the same as the image the host wrote, because that image is already sitting in the SRAM region. To tell the two apart, the bench's memory model can corrupt one programmed byte. The bench then expects that altered value, not the original, at the matching SRAM address. A second hard case is a command that arrives mid-operation. The bench issues it during the erase stall, when the phase is known to be PROG_OP. It then checks that the store still finishes with a single erase.

// File: rtl/cfgupd_pkg.sv
package cfgupd_pkg;
    localparam int BYTE_W = 8;

    localparam logic [1:0] CMD_STORE  = 2'd1;
    localparam logic [1:0] CMD_RELOAD = 2'd2;

    localparam logic [7:0] OPC_ERASE  = 8'hE5;
    localparam logic [7:0] OPC_PROG   = 8'h5A;
    localparam logic [7:0] OPC_READ   = 8'hA5;
    localparam logic [7:0] OPC_RELOAD = 8'hC3;

    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_ERASE      = 4'd1,
        ST_PROG_OP    = 4'd2,
        ST_PROG_ADR   = 4'd3,
        ST_PROG_FETCH = 4'd4,
        ST_PROG_DATA  = 4'd5,
        ST_READ_OP    = 4'd6,
        ST_READ_ADR   = 4'd7,
        ST_READ_REQ   = 4'd8,
        ST_READ_WAIT  = 4'd9,
        ST_RELOAD     = 4'd10
    } state_t;
endpackage

// File: rtl/cfgupd_sram_mux.sv
module cfgupd_sram_mux
    import cfgupd_pkg::*;
#(
    parameter int SRAM_AW = 10
) (
    input  logic               ctl_own,
    input  logic [SRAM_AW-1:0] h_addr,
    input  logic [BYTE_W-1:0]  h_wdata,
    input  logic               h_we,
    output logic [BYTE_W-1:0]  h_rdata,
    input  logic [SRAM_AW-1:0] ctl_addr,
    input  logic [BYTE_W-1:0]  ctl_wdata,
    input  logic               ctl_we,
    output logic [BYTE_W-1:0]  ctl_rdata,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [BYTE_W-1:0]  sram_wdata,
    output logic               sram_we,
    input  logic [BYTE_W-1:0]  sram_rdata
);
    // the side that does not own the port is cut off completely
    always_comb begin
        if (ctl_own) begin
            sram_addr  = ctl_addr;
            sram_wdata = ctl_wdata;
            sram_we    = ctl_we;
        end else begin
            sram_addr  = h_addr;
            sram_wdata = h_wdata;
            sram_we    = h_we;
        end
    end

    assign h_rdata   = sram_rdata;
    assign ctl_rdata = sram_rdata;
endmodule

// File: rtl/cfgupd_fsm.sv
module cfgupd_fsm
    import cfgupd_pkg::*;
#(
    parameter int SRAM_AW = 10,
    parameter int LEN_W   = 10,
    parameter int MEM_AW  = 16,
    parameter int TGT_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_code,
    input  logic [SRAM_AW-1:0] cfg_base,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [MEM_AW-1:0]  seg_off,
    input  logic [TGT_W-1:0]   tgt_sel,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [3:0]         phase,
    output logic               mem_req,
    output logic               mem_op,
    output logic [BYTE_W-1:0]  mem_byte,
    output logic [TGT_W-1:0]   mem_tgt,
    input  logic               mem_busy,
    input  logic               mem_rd_valid,
    input  logic [BYTE_W-1:0]  mem_rd_byte,
    output logic               ctl_own,
    output logic [SRAM_AW-1:0] ctl_addr,
    output logic               ctl_we,
    output logic [BYTE_W-1:0]  ctl_wdata,
    input  logic [BYTE_W-1:0]  ctl_rdata
);
    localparam int ADDR_BYTES = MEM_AW / BYTE_W;
    localparam int AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    state_t             state, state_n;
    logic [LEN_W-1:0]   idx, idx_n;
    logic [AB_W-1:0]    ab, ab_n;
    logic               done_n, err_n, load;
    logic [SRAM_AW-1:0] base_q;
    logic [LEN_W-1:0]   len_q;
    logic [MEM_AW-1:0]  off_q;
    logic [TGT_W-1:0]   tgt_q;
    logic               accept, last_ab, last_idx;
    logic [MEM_AW-1:0]  off_shift;
    logic [BYTE_W-1:0]  addr_byte;

    assign accept   = mem_req && !mem_busy;
    assign last_ab  = (ab == AB_W'(ADDR_BYTES - 1));
    assign last_idx = (idx == len_q - LEN_W'(1));

    // address bytes leave most significant first
    always_comb begin
        off_shift = off_q >> (BYTE_W * (ADDR_BYTES - 1 - int'(ab)));
        addr_byte = off_shift[BYTE_W-1:0];
    end

    // next-state and counter logic
    always_comb begin
        state_n = state;
        idx_n   = idx;
        ab_n    = ab;
        done_n  = done;
        err_n   = err;
        load    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_code == CMD_STORE && cfg_len != '0) begin
                        load    = 1'b1;
                        done_n  = 1'b0;
                        idx_n   = '0;
                        ab_n    = '0;
                        state_n = (seg_off == '0) ? ST_ERASE : ST_PROG_OP;
                    end else if (cmd_code == CMD_RELOAD && done) begin
                        load    = 1'b1;
                        done_n  = 1'b0;
                        state_n = ST_RELOAD;
                    end else begin
                        err_n = 1'b1;
                    end
                end
            end
            ST_ERASE:      if (accept) state_n = ST_PROG_OP;
            ST_PROG_OP: begin
                if (accept) begin
                    ab_n    = '0;
                    state_n = ST_PROG_ADR;
                end
            end
            ST_PROG_ADR: begin
                if (accept) begin
                    ab_n    = ab + AB_W'(1);
                    if (last_ab) state_n = ST_PROG_FETCH;
                end
            end
            ST_PROG_FETCH: state_n = ST_PROG_DATA;
            ST_PROG_DATA: begin
                if (accept) begin
                    if (last_idx) begin
                        idx_n   = '0;
                        state_n = ST_READ_OP;
                    end else begin
                        idx_n   = idx + LEN_W'(1);
                        state_n = ST_PROG_FETCH;
                    end
                end
            end
            ST_READ_OP: begin
                if (accept) begin
                    ab_n    = '0;
                    state_n = ST_READ_ADR;
                end
            end
            ST_READ_ADR: begin
                if (accept) begin
                    ab_n    = ab + AB_W'(1);
                    if (last_ab) state_n = ST_READ_REQ;
                end
            end
            ST_READ_REQ:   if (accept) state_n = ST_READ_WAIT;
            ST_READ_WAIT: begin
                if (mem_rd_valid) begin
                    if (last_idx) begin
                        done_n  = 1'b1;
                        state_n = ST_IDLE;
                    end else begin
                        idx_n   = idx + LEN_W'(1);
                        state_n = ST_READ_REQ;
                    end
                end
            end
            ST_RELOAD:     if (accept) state_n = ST_IDLE;
            default:       state_n = ST_IDLE;
        endcase
        if (state != ST_IDLE && cmd_valid) err_n = 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            ab     <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            base_q <= '0;
            len_q  <= '0;
            off_q  <= '0;
            tgt_q  <= '0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
            ab    <= ab_n;
            done  <= done_n;
            err   <= err_n;
            if (load) begin
                base_q <= cfg_base;
                len_q  <= cfg_len;
                off_q  <= seg_off;
                tgt_q  <= tgt_sel;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_op   = 1'b0;
        mem_byte = '0;
        ctl_we   = 1'b0;
        unique case (state)
            ST_ERASE:     begin mem_req = 1'b1; mem_op = 1'b1; mem_byte = OPC_ERASE;  end
            ST_PROG_OP:   begin mem_req = 1'b1; mem_op = 1'b1; mem_byte = OPC_PROG;   end
            ST_READ_OP:   begin mem_req = 1'b1; mem_op = 1'b1; mem_byte = OPC_READ;   end
            ST_RELOAD:    begin mem_req = 1'b1; mem_op = 1'b1; mem_byte = OPC_RELOAD; end
            ST_PROG_ADR,
            ST_READ_ADR:  begin mem_req = 1'b1; mem_byte = addr_byte; end
            ST_PROG_DATA: begin mem_req = 1'b1; mem_byte = ctl_rdata; end
            ST_READ_REQ:  mem_req = 1'b1;
            ST_READ_WAIT: ctl_we  = mem_rd_valid;
            default: ;
        endcase
    end

    assign busy      = (state != ST_IDLE);
    assign ctl_own   = busy && (state != ST_RELOAD);
    assign ctl_addr  = base_q + SRAM_AW'(idx);
    assign ctl_wdata = mem_rd_byte;
    assign phase     = state;
    assign mem_tgt   = tgt_q;
endmodule

// File: rtl/cfg_image_updater.sv
module cfg_image_updater
    import cfgupd_pkg::*;
#(
    parameter int SRAM_AW = 10,
    parameter int LEN_W   = 10,
    parameter int MEM_AW  = 16,
    parameter int TGT_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_code,
    input  logic [SRAM_AW-1:0] cfg_base,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [MEM_AW-1:0]  seg_off,
    input  logic [TGT_W-1:0]   tgt_sel,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [3:0]         phase,
    input  logic [SRAM_AW-1:0] h_addr,
    input  logic [7:0]         h_wdata,
    input  logic               h_we,
    output logic [7:0]         h_rdata,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [7:0]         sram_wdata,
    output logic               sram_we,
    input  logic [7:0]         sram_rdata,
    output logic               mem_req,
    output logic               mem_op,
    output logic [7:0]         mem_byte,
    output logic [TGT_W-1:0]   mem_tgt,
    input  logic               mem_busy,
    input  logic               mem_rd_valid,
    input  logic [7:0]         mem_rd_byte
);
    logic               ctl_own, ctl_we;
    logic [SRAM_AW-1:0] ctl_addr;
    logic [BYTE_W-1:0]  ctl_wdata, ctl_rdata;

    cfgupd_fsm #(
        .SRAM_AW(SRAM_AW), .LEN_W(LEN_W), .MEM_AW(MEM_AW), .TGT_W(TGT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cfg_base(cfg_base),
        .cfg_len(cfg_len), .seg_off(seg_off), .tgt_sel(tgt_sel),
        .busy(busy), .done(done), .err(err), .phase(phase),
        .mem_req(mem_req), .mem_op(mem_op), .mem_byte(mem_byte), .mem_tgt(mem_tgt),
        .mem_busy(mem_busy), .mem_rd_valid(mem_rd_valid), .mem_rd_byte(mem_rd_byte),
        .ctl_own(ctl_own), .ctl_addr(ctl_addr), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata)
    );

    cfgupd_sram_mux #(.SRAM_AW(SRAM_AW)) u_mux (
        .ctl_own(ctl_own),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_we(h_we), .h_rdata(h_rdata),
        .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_we(ctl_we), .ctl_rdata(ctl_rdata),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
        .sram_rdata(sram_rdata)
    );
endmodule

// File: rtl/cfgupd_chk.sv
module cfgupd_chk #(
    parameter int SRAM_AW = 10,
    parameter int TGT_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic [3:0]         phase,
    input logic [SRAM_AW-1:0] h_addr,
    input logic [7:0]         h_wdata,
    input logic               h_we,
    input logic [SRAM_AW-1:0] sram_addr,
    input logic [7:0]         sram_wdata,
    input logic               sram_we,
    input logic               mem_req,
    input logic               mem_op,
    input logic [7:0]         mem_byte,
    input logic [TGT_W-1:0]   mem_tgt,
    input logic               mem_busy,
    input logic               mem_rd_valid,
    input logic [7:0]         mem_rd_byte
);
    // R1: while idle the host drives the SRAM
    p_host_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sram_addr == h_addr && sram_we == h_we && sram_wdata == h_wdata));

    // R3: an offered byte is held unchanged until accepted
    p_hold_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_busy) |=> (mem_req && $stable(mem_byte) && $stable(mem_op)));

    // R5: controller writes to SRAM only with a readback byte
    p_rb_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sram_we) |-> (mem_rd_valid && sram_wdata == mem_rd_byte));

    // R6: finishing the readback raises done
    p_done_after_rb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(phase) == 4'd9) |-> done);

    // R6: done never shows while busy
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: a command while busy sets err, and err is sticky
    p_busy_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> err);
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R10: target held stable across an operation
    p_tgt_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_tgt));
endmodule

bind cfg_image_updater cfgupd_chk #(.SRAM_AW(SRAM_AW), .TGT_W(TGT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
    .err(err), .phase(phase), .h_addr(h_addr), .h_wdata(h_wdata), .h_we(h_we),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
    .mem_req(mem_req), .mem_op(mem_op), .mem_byte(mem_byte), .mem_tgt(mem_tgt),
    .mem_busy(mem_busy), .mem_rd_valid(mem_rd_valid), .mem_rd_byte(mem_rd_byte)
);

// File: tb/sim_cfg_image_updater.sv
`timescale 1ns/1ps
module sim_cfg_image_updater;
    localparam int SRAM_AW   = 10;
    localparam int LEN_W     = 10;
    localparam int MEM_AW    = 16;
    localparam int TGT_W     = 2;
    localparam int ERASE_CYC = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic               cmd_valid = 1'b0;
    logic [1:0]         cmd_code = 2'd0;
    logic [SRAM_AW-1:0] cfg_base = '0;
    logic [LEN_W-1:0]   cfg_len = '0;
    logic [MEM_AW-1:0]  seg_off = '0;
    logic [TGT_W-1:0]   tgt_sel = '0;
    logic               busy, done, err;
    logic [3:0]         phase;
    logic [SRAM_AW-1:0] h_addr = '0;
    logic [7:0]         h_wdata = '0;
    logic               h_we = 1'b0;
    logic [7:0]         h_rdata;
    logic [SRAM_AW-1:0] sram_addr;
    logic [7:0]         sram_wdata;
    logic               sram_we;
    logic [7:0]         sram_rdata = '0;
    logic               mem_req, mem_op;
    logic [7:0]         mem_byte;
    logic [TGT_W-1:0]   mem_tgt;
    logic               mem_busy;
    logic               mem_rd_valid = 1'b0;
    logic [7:0]         mem_rd_byte = '0;

    cfg_image_updater #(.SRAM_AW(SRAM_AW), .LEN_W(LEN_W), .MEM_AW(MEM_AW), .TGT_W(TGT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cfg_base(cfg_base), .cfg_len(cfg_len), .seg_off(seg_off), .tgt_sel(tgt_sel),
        .busy(busy), .done(done), .err(err), .phase(phase),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_we(h_we), .h_rdata(h_rdata),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
        .sram_rdata(sram_rdata),
        .mem_req(mem_req), .mem_op(mem_op), .mem_byte(mem_byte), .mem_tgt(mem_tgt),
        .mem_busy(mem_busy), .mem_rd_valid(mem_rd_valid), .mem_rd_byte(mem_rd_byte)
    );

    // staging SRAM model, one-cycle read latency
    logic [7:0] sram [1024];
    initial for (int k = 0; k < 1024; k++) sram[k] = 8'h00;
    always @(posedge clk) begin
        if (sram_we) sram[sram_addr] <= sram_wdata;
        sram_rdata <= sram[sram_addr];
    end

    // configuration memory model
    logic [7:0] flash [4][256];
    initial for (int t = 0; t < 4; t++) for (int k = 0; k < 256; k++) flash[t][k] = 8'hFF;
    logic [7:0]  op_log [64];
    int          oplen = 0, n_erase = 0, n_reload = 0, bad_op = 0, pcount = 0;
    int          busy_cnt = 0, rd_cnt = 0;
    logic [7:0]  mode = 8'h00, waddr = 8'h00, raddr = 8'h00, mhi = 8'h00;
    logic [15:0] prog_start = 16'h0000;
    logic [1:0]  mab = 2'd0;
    logic [TGT_W-1:0] rl_tgt = '0;
    logic        fault = 1'b0;
    assign mem_busy = (busy_cnt != 0);

    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        if (rd_cnt != 0) begin
            rd_cnt <= rd_cnt - 1;
            if (rd_cnt == 1) begin
                mem_rd_valid <= 1'b1;
                mem_rd_byte  <= flash[mem_tgt][raddr];
                raddr        <= raddr + 8'd1;
            end
        end
        if (mem_req && !mem_busy) begin
            if (mem_op) begin
                op_log[oplen[5:0]] <= mem_byte;
                oplen <= oplen + 1;
                mab   <= 2'd0;
                mode  <= mem_byte;
                case (mem_byte)
                    8'hE5: begin
                        for (int k = 0; k < 256; k++) flash[mem_tgt][k] <= 8'hFF;
                        n_erase  <= n_erase + 1;
                        busy_cnt <= ERASE_CYC;
                    end
                    8'h5A: pcount <= 0;
                    8'hA5: ;
                    8'hC3: begin n_reload <= n_reload + 1; rl_tgt <= mem_tgt; end
                    default: bad_op <= bad_op + 1;
                endcase
            end else if (mab < 2'd2) begin
                mab <= mab + 2'd1;
                if (mab == 2'd0) mhi <= mem_byte;
                else begin
                    waddr <= mem_byte;
                    raddr <= mem_byte;
                    if (mode == 8'h5A) prog_start <= {mhi, mem_byte};
                end
            end else if (mode == 8'h5A) begin
                flash[mem_tgt][waddr] <= flash[mem_tgt][waddr] &
                    ((fault && pcount == 5) ? (mem_byte ^ 8'h01) : mem_byte);
                waddr    <= waddr + 8'd1;
                pcount   <= pcount + 1;
                busy_cnt <= 2;
            end else if (mode == 8'hA5) begin
                if (mem_byte != 8'h00) bad_op <= bad_op + 1;
                rd_cnt <= 3;
            end else begin
                bad_op <= bad_op + 1;
            end
        end
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic hwrite(input int a, input int d);
        h_addr = SRAM_AW'(a); h_wdata = 8'(d); h_we = 1'b1;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic hread(input int a, output int d);
        h_addr = SRAM_AW'(a);
        @(negedge clk);
        d = int'(h_rdata);
    endtask

    task automatic issue(input int code, input int base, input int len, input int off, input int tgt);
        cmd_code = 2'(code); cfg_base = SRAM_AW'(base); cfg_len = LEN_W'(len);
        seg_off = MEM_AW'(off); tgt_sel = TGT_W'(tgt); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        chk("R6 completion", int'(busy), 0);
    endtask

    function automatic int img(input int seed, input int i);
        return (seed + i * 7 + (i >> 1)) & 8'hFF;
    endfunction

    task automatic load_image(input int base, input int len, input int seed);
        for (int i = 0; i < len; i++) hwrite(base + i, img(seed, i));
    endtask

    task automatic t_reset();
        int d;
        do_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);
        chk("R1 phase", int'(phase), 0);
        hwrite(3, 8'h5C);
        hread(3, d);
        chk("R1 host sram", d, 8'h5C);
    endtask

    task automatic t_store_basic();
        int d, ops0, er0;
        do_reset();
        load_image(12'h040, 16, 8'h30);
        ops0 = oplen; er0 = n_erase;
        issue(1, 12'h040, 16, 0, 0);
        @(negedge clk);
        chk("R9 phase in erase stall", int'(phase), 2);
        chk("R3 memory busy after erase", int'(mem_busy), 1);
        hwrite(12'h300, 8'h77);
        wait_idle();
        chk("R6 done", int'(done), 1);
        chk("R8 no err", int'(err), 0);
        chk("R3 one erase", n_erase - er0, 1);
        chk("R4 opcode count", oplen - ops0, 3);
        chk("R3 first opcode", int'(op_log[ops0[5:0]]), 8'hE5);
        chk("R4 second opcode", int'(op_log[6'(ops0 + 1)]), 8'h5A);
        chk("R5 third opcode", int'(op_log[6'(ops0 + 2)]), 8'hA5);
        chk("R4 no stray op", bad_op, 0);
        chk("R4 data byte count", pcount, 16);
        chk("R4 start address", int'(prog_start), 0);
        for (int i = 0; i < 16; i++) chk("R4 memory content", int'(flash[0][i]), img(8'h30, i));
        for (int i = 0; i < 16; i++) begin
            hread(12'h040 + i, d);
            chk("R5 sram readback", d, img(8'h30, i));
        end
        hread(12'h300, d);
        chk("R2 host write blocked", d, 0);
    endtask

    task automatic t_fault_readback();
        int d;
        do_reset();
        load_image(12'h100, 8, 8'h91);
        fault = 1'b1;
        issue(1, 12'h100, 8, 0, 2);
        wait_idle();
        fault = 1'b0;
        chk("R6 done", int'(done), 1);
        hread(12'h105, d);
        chk("R5 readback from memory", d, img(8'h91, 5) ^ 1);
        hread(12'h104, d);
        chk("R5 readback unaltered byte", d, img(8'h91, 4));
        chk("R10 target 2 written", int'(flash[2][0]), img(8'h91, 0));
        chk("R10 target 3 untouched", int'(flash[3][0]), 8'hFF);
    endtask

    task automatic t_segments();
        int d, er0, rl0;
        do_reset();
        er0 = n_erase;
        load_image(12'h080, 8, 8'h11);
        issue(1, 12'h080, 8, 0, 1);
        wait_idle();
        chk("R6 seg0 done", int'(done), 1);
        load_image(12'h0C0, 8, 8'h4B);
        issue(1, 12'h0C0, 8, 8, 1);
        wait_idle();
        chk("R6 seg1 done", int'(done), 1);
        chk("R3 erase only on first segment", n_erase - er0, 1);
        chk("R4 segment start address", int'(prog_start), 8);
        for (int i = 0; i < 8; i++) begin
            chk("R4 seg0 kept", int'(flash[1][i]), img(8'h11, i));
            chk("R4 seg1 placed", int'(flash[1][8 + i]), img(8'h4B, i));
        end
        hread(12'h0C3, d);
        chk("R5 seg1 readback", d, img(8'h4B, 3));
        rl0 = n_reload;
        issue(2, 0, 0, 0, 1);
        chk("R9 reload phase", int'(phase), 10);
        wait_idle();
        chk("R7 one reload", n_reload - rl0, 1);
        chk("R10 reload target", int'(rl_tgt), 1);
        chk("R6 done cleared", int'(done), 0);
        chk("R8 no err", int'(err), 0);
    endtask

    task automatic t_errors();
        int rl0, ops0, er0;
        do_reset();
        rl0 = n_reload;
        issue(2, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R7 reload refused without done", n_reload - rl0, 0);
        chk("R8 err on early reload", int'(err), 1);
        chk("R8 stays idle", int'(busy), 0);
        do_reset();
        ops0 = oplen;
        issue(1, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R8 zero length ignored", oplen - ops0, 0);
        chk("R8 err on zero length", int'(err), 1);
        do_reset();
        issue(3, 0, 4, 0, 0);
        @(negedge clk);
        chk("R8 err on bad code", int'(err), 1);
        chk("R8 bad code stays idle", int'(busy), 0);
        do_reset();
        er0 = n_erase;
        load_image(12'h200, 4, 8'h66);
        issue(1, 12'h200, 4, 0, 3);
        @(negedge clk);
        chk("R9 erase stall phase", int'(phase), 2);
        issue(1, 12'h200, 4, 0, 3);
        chk("R8 err on busy command", int'(err), 1);
        wait_idle();
        chk("R8 busy command ignored", n_erase - er0, 1);
        chk("R6 store still done", int'(done), 1);
        chk("R8 err sticky", int'(err), 1);
    endtask

    initial begin
        t_reset();
        t_store_basic();
        t_fault_readback();
        t_segments();
        t_errors();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule